// File: doc/BRIEF.md
# Byte-accessed 16-bit timer counter

This block is a 16-bit timer counter that a processor reaches through an 8-bit register bus. Each 16-bit value (the running count and a 16-bit ceiling called TOP) appears as a low-byte location and a high-byte location. Software never touches a live high byte. High-byte accesses go to a holding register, and the counter and TOP each have their own. Reading a low byte also captures the matching high byte. Writing a low byte commits the whole word. As a result, every 16-bit transfer is atomic even while the counter is moving.

The counter advances on a tick enable. A 3-bit clock-select field picks the tick source: stopped, every system clock, or one of four fixed divisions of a free-running prescaler. A 2-bit mode field picks how the count moves on a tick: free-running up, up to TOP and then clear, or a triangle between 0 and TOP. An overflow flag is raised at a point that depends on the mode. The flag is cleared by writing 1 to it, and together with an enable bit it drives an interrupt request.

Top module: `tick_counter16`

## Requirements
- R1: After reset the count reads 0x0000, TOP reads 0xFFFF, the control byte reads 0x00, the status byte reads 0x00 and `irq` is 0.
- R2: Address 0 returns the count's low byte, and address 1 returns the count's holding register. A read strobe at address 0 copies the count's high byte into the holding register on the same edge. A low-then-high read therefore returns the word as it stood at the low-byte read, even across a carry.
- R3: A write to address 1 changes only the holding register, not the count. A write to address 0 loads the whole count at once, with the holding register as the high byte and the bus byte as the low byte.
- R4: A count load at address 0 takes effect exactly on its edge and overrides any tick, clear or count on that edge.
- R5: Control bits [2:0] select the tick. Value 1 ticks on every clock. Values 2, 3, 4 and 5 tick once per 8, 64, 256 and 1024 clocks of a free-running prescaler. Values 0, 6 and 7 stop the counter, and both count bytes stay readable and writable while it is stopped.
- R6: Mode (control bits [4:3]) 0, and the unused value 3, count up and wrap from 0xFFFF to 0x0000, setting the overflow flag on the wrap tick.
- R7: Mode 1 counts up. On a tick where the count equals TOP it clears to 0 instead and sets the overflow flag.
- R8: Mode 2 counts up to TOP, then down. The flag is set on the tick that brings the count down to 0, and the count then rises again, so the period is 2*TOP ticks. With TOP 0 the count holds at 0.
- R9: The overflow flag is status bit 0 at address 5. It stays set until a write to address 5 with bit 0 high. A write with bit 0 low leaves it alone, and a set on the same edge as a clear wins.
- R10: `irq` is high exactly when the overflow flag is set and the interrupt enable (control bit 7) is 1.
- R11: TOP uses addresses 2 (low) and 3 (high holding) with the same capture and commit scheme as the count. Its holding register is separate from the count's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address (0 count low, 1 count high, 2 TOP low, 3 TOP high, 4 control, 5 status) |
| wr_en | input | 1 | Write strobe, acts on the rising edge |
| rd_en | input | 1 | Read strobe, triggers the high-byte capture side effect |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the location at `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle: the high-byte capture on a low-byte read, the exact word committed by a low-byte write on that edge, a frozen count while the counter is stopped, and the wrap-and-flag step of the normal mode. They also check that the flag is sticky and that `irq` stays low with the enable clear. The bench scenarios cover what only a sequence can show. These are the coherent word across a carry between two byte reads, the tick counts per prescaler setting over a fixed window, and the step-by-step counts and flag timing in clear-at-TOP and triangle modes over a sweep of small TOP values. They also include the set-versus-clear collision and the separation of the two holding registers.

// File: rtl/tc16_pkg.sv
package tc16_pkg;

    localparam int CNT_W  = 16;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 10;
    localparam int CS_W   = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_TOP_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_TOP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_UPDN   = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef struct packed {
        logic            ie;
        logic [1:0]      spare;
        mode_e           mode;
        logic [CS_W-1:0] cs;
    } ctrl_t;

    // log2 of the tick divider for each active clock-select code
    function automatic int cs_shift(input int code);
        case (code)
            1:       return 0;
            2:       return 3;
            3:       return 6;
            4:       return 8;
            5:       return 10;
            default: return 0;
        endcase
    endfunction

    function automatic logic cs_active(input int code);
        return (code >= 1) && (code <= 5);
    endfunction

endpackage

// File: rtl/tc16_prescale.sv
module tc16_prescale
    import tc16_pkg::*;
#(
    parameter int PW  = PRE_W,
    parameter int CSW = CS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CSW-1:0] cs,
    output logic           tick
);
    localparam int NSEL = 1 << CSW;

    logic [PW-1:0]   presc_q;
    logic [NSEL-1:0] opt;

    always_ff @(posedge clk) begin
        if (rst) presc_q <= '0;
        else     presc_q <= presc_q + {{(PW-1){1'b0}}, 1'b1};
    end

    // one tick candidate per select code; unused codes never tick
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        if (cs_active(g)) begin : g_on
            localparam logic [PW-1:0] MASK = PW'((1 << cs_shift(g)) - 1);
            assign opt[g] = ((presc_q & MASK) == MASK);
        end else begin : g_off
            assign opt[g] = 1'b0;
        end
    end

    assign tick = opt[cs];

endmodule

// File: rtl/tc16_core.sv
module tc16_core
    import tc16_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  mode_e         mode,
    input  logic [CW-1:0] top,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          ovf_clr,
    output logic [CW-1:0] cnt,
    output logic          flag
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q, cnt_nx;
    logic          dn_q, dn_nx;
    logic          hit;
    logic          flag_q;

    always_comb begin
        cnt_nx = cnt_q;
        dn_nx  = dn_q;
        hit    = 1'b0;
        if (mode != MODE_UPDN) dn_nx = 1'b0;
        if (tick) begin
            case (mode)
                MODE_CTC: begin
                    if (cnt_q == top) begin
                        cnt_nx = '0;
                        hit    = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + ONE;
                    end
                end
                MODE_UPDN: begin
                    if (!dn_q) begin
                        if (cnt_q < top) begin
                            cnt_nx = cnt_q + ONE;
                        end else if (cnt_q != '0) begin
                            cnt_nx = cnt_q - ONE;
                            if (cnt_q == ONE) hit   = 1'b1;
                            else              dn_nx = 1'b1;
                        end
                    end else begin
                        if (cnt_q == '0) begin
                            dn_nx = 1'b0;
                        end else begin
                            cnt_nx = cnt_q - ONE;
                            if (cnt_q == ONE) begin
                                hit   = 1'b1;
                                dn_nx = 1'b0;
                            end
                        end
                    end
                end
                default: begin
                    cnt_nx = cnt_q + ONE;
                    hit    = (cnt_q == '1);
                end
            endcase
        end
        // a bus load overrides any count step on the same edge
        if (load) begin
            cnt_nx = load_val;
            hit    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            dn_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            dn_q   <= dn_nx;
            flag_q <= hit | (flag_q & ~ovf_clr);
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

endmodule

// File: rtl/tc16_regs.sv
module tc16_regs
    import tc16_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = BUS_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] cnt,
    input  logic          flag,
    output logic [DW-1:0] rdata,
    output ctrl_t         ctrl,
    output logic [CW-1:0] top,
    output logic [DW-1:0] temp_cnt,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          ovf_clr
);
    logic [DW-1:0] temp_cnt_q, temp_top_q;
    logic [CW-1:0] top_q;
    ctrl_t         ctrl_q;

    logic wr_cnt_hi, wr_top_lo, wr_top_hi, wr_ctrl, rd_cnt_lo, rd_top_lo;

    assign wr_cnt_hi = wr_en && (addr == A_CNT_HI);
    assign wr_top_lo = wr_en && (addr == A_TOP_LO);
    assign wr_top_hi = wr_en && (addr == A_TOP_HI);
    assign wr_ctrl   = wr_en && (addr == A_CTRL);
    assign rd_cnt_lo = rd_en && (addr == A_CNT_LO);
    assign rd_top_lo = rd_en && (addr == A_TOP_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_cnt_q <= '0;
            temp_top_q <= '0;
            top_q      <= '1;
            ctrl_q     <= '0;
        end else begin
            if (wr_cnt_hi)      temp_cnt_q <= wdata;
            else if (rd_cnt_lo) temp_cnt_q <= cnt[CW-1:CW-DW];

            if (wr_top_hi)      temp_top_q <= wdata;
            else if (rd_top_lo) temp_top_q <= top_q[CW-1:CW-DW];

            if (wr_top_lo) top_q <= {temp_top_q, wdata};

            if (wr_ctrl) begin
                ctrl_q.ie    <= wdata[7];
                ctrl_q.spare <= 2'b00;
                ctrl_q.mode  <= mode_e'(wdata[4:3]);
                ctrl_q.cs    <= wdata[2:0];
            end
        end
    end

    always_comb begin
        case (addr)
            A_CNT_LO: rdata = cnt[DW-1:0];
            A_CNT_HI: rdata = temp_cnt_q;
            A_TOP_LO: rdata = top_q[DW-1:0];
            A_TOP_HI: rdata = temp_top_q;
            A_CTRL:   rdata = ctrl_q;
            A_STAT:   rdata = {{(DW-1){1'b0}}, flag};
            default:  rdata = '0;
        endcase
    end

    assign load     = wr_en && (addr == A_CNT_LO);
    assign load_val = {temp_cnt_q, wdata};
    assign ovf_clr  = wr_en && (addr == A_STAT) && wdata[0];
    assign ctrl     = ctrl_q;
    assign top      = top_q;
    assign temp_cnt = temp_cnt_q;

endmodule

// File: rtl/tick_counter16.sv
module tick_counter16
    import tc16_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = BUS_W,
    parameter int AW = ADDR_W,
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    ctrl_t         ctrl_q;
    logic          tick;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] top_q;
    logic [CW-1:0] load_val;
    logic [DW-1:0] temp_cnt;
    logic          load;
    logic          ovf_clr;
    logic          flag_q;

    tc16_prescale #(.PW(PW), .CSW(CS_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .cs   (ctrl_q.cs),
        .tick (tick)
    );

    tc16_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .cnt      (cnt_q),
        .flag     (flag_q),
        .rdata    (rdata),
        .ctrl     (ctrl_q),
        .top      (top_q),
        .temp_cnt (temp_cnt),
        .load     (load),
        .load_val (load_val),
        .ovf_clr  (ovf_clr)
    );

    tc16_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (ctrl_q.mode),
        .top      (top_q),
        .load     (load),
        .load_val (load_val),
        .ovf_clr  (ovf_clr),
        .cnt      (cnt_q),
        .flag     (flag_q)
    );

    assign irq = flag_q & ctrl_q.ie;

endmodule

// File: rtl/tc16_checker.sv
module tc16_checker #(
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] wdata,
    input logic          tick,
    input logic [1:0]    mode,
    input logic [2:0]    cs,
    input logic [CW-1:0] cnt,
    input logic [DW-1:0] temp_cnt,
    input logic          flag,
    input logic          ie,
    input logic          irq
);
    logic cnt_load;
    assign cnt_load = wr_en && (addr == '0);

    p_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == '0) |=> (temp_cnt == $past(cnt[CW-1:CW-DW])));

    p_load_prio_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> (cnt == {$past(temp_cnt), $past(wdata)}));

    p_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        ((cs == 3'd0 || cs > 3'd5) && !cnt_load) |=> $stable(cnt));

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == 2'd0 && cnt == '1 && !cnt_load) |=> (cnt == '0 && flag));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_en && addr == 3'd5 && wdata[0])) |=> flag);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !ie |-> !irq);

endmodule

bind tick_counter16 tc16_checker #(.CW(CW), .DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .tick     (tick),
    .mode     (ctrl_q.mode),
    .cs       (ctrl_q.cs),
    .cnt      (cnt_q),
    .temp_cnt (temp_cnt),
    .flag     (flag_q),
    .ie       (ctrl_q.ie),
    .irq      (irq)
);

// File: tb/tick_counter16_bench.sv
`timescale 1ns/1ps
module tick_counter16_bench;

    localparam int CYC = 20;
    localparam logic [2:0] CNT_LO = 3'd0, CNT_HI = 3'd1, TOP_LO = 3'd2,
                           TOP_HI = 3'd3, CTRL = 3'd4, STAT = 3'd5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #(CYC/2) clk = ~clk;

    tick_counter16 u_tick_counter16 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rd_word(input logic [2:0] lo_a, output logic [15:0] w);
        logic [7:0] lo, hi;
        rd(lo_a, lo);
        rd(lo_a + 3'd1, hi);
        w = {hi, lo};
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic load_word(input logic [2:0] lo_a, input logic [15:0] v);
        wr(lo_a + 3'd1, v[15:8]);
        wr(lo_a, v[7:0]);
    endtask

    // exactly n ticks at clock-select 1 (or n clocks of prescaler at cs)
    task automatic run(input int n, input logic [7:0] base, input logic [2:0] cs);
        wr(CTRL, base | {5'd0, cs});
        for (int i = 0; i < n - 1; i++) idle();
        wr(CTRL, base);
    endtask

    task automatic model_step(input int md, input logic [15:0] tp,
                              inout logic [15:0] c, inout logic dn, output logic h);
        h = 1'b0;
        if (md == 1) begin
            if (c == tp) begin c = 16'd0; h = 1'b1; end
            else c = c + 16'd1;
        end else if (md == 2) begin
            if (!dn) begin
                if (c < tp) c = c + 16'd1;
                else if (c != 16'd0) begin
                    if (c == 16'd1) h = 1'b1; else dn = 1'b1;
                    c = c - 16'd1;
                end
            end else begin
                if (c == 16'd0) dn = 1'b0;
                else begin
                    if (c == 16'd1) begin h = 1'b1; dn = 1'b0; end
                    c = c - 16'd1;
                end
            end
        end else begin
            h = (c == 16'hFFFF);
            c = c + 16'd1;
        end
    endtask

    initial begin
        #(CYC * 150000);
        failures++;
        $display("FAIL watchdog R1..all actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [7:0]  b;
        int          exp_ticks[8];
        exp_ticks = '{0, 1024, 128, 16, 4, 1, 0, 0};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd_word(CNT_LO, w); check("R1 count", w, 16'h0000);
        rd_word(TOP_LO, w); check("R1 top", w, 16'hFFFF);
        rd(CTRL, b);        check("R1 ctrl", b, 8'h00);
        rd(STAT, b);        check("R1 status", b, 8'h00);
        check("R1 irq", irq, 0);

        // R2 coherent word across a low-byte carry
        load_word(CNT_LO, 16'h12FF);
        wr(CTRL, 8'h01);
        rd_word(CNT_LO, w);
        check("R2 coherent read", w, 16'h12FF);
        wr(CTRL, 8'h00);
        rd_word(CNT_LO, w);
        check("R5 tick per clock at cs1", w, 16'h1302);

        // R3 / R11 holding registers are separate
        wr(CNT_HI, 8'h11);
        load_word(TOP_LO, 16'h2233);
        wr(CNT_LO, 8'h44);
        rd_word(CNT_LO, w); check("R3 count commit", w, 16'h1144);
        rd_word(TOP_LO, w); check("R11 top separate", w, 16'h2233);
        wr(CNT_HI, 8'h55);
        rd(CNT_LO, b);      check("R3 high write alone", b, 8'h44);
        rd(CNT_HI, b);      check("R3 high write alone hi", b, 8'h11);

        // R4 load overrides a tick on the same edge
        wr(CTRL, 8'h01);
        wr(CNT_HI, 8'hAB);
        wr(CNT_LO, 8'hCD);
        wr(CTRL, 8'h00);
        rd_word(CNT_LO, w); check("R4 write priority", w, 16'hABCE);

        // R5 tick rate per clock-select value over a 1024-clock window
        for (int cs = 0; cs < 8; cs++) begin
            load_word(CNT_LO, 16'h0000);
            run(1024, 8'h00, 3'(cs));
            rd_word(CNT_LO, w);
            check($sformatf("R5 ticks cs=%0d", cs), w, exp_ticks[cs]);
        end

        // R6 normal wrap and flag
        load_word(CNT_LO, 16'hFFFD);
        wr(STAT, 8'h01);
        run(2, 8'h00, 3'd1);
        rd_word(CNT_LO, w); check("R6 before wrap", w, 16'hFFFF);
        rd(STAT, b);        check("R6 no flag yet", b, 8'h00);
        run(1, 8'h00, 3'd1);
        rd_word(CNT_LO, w); check("R6 wrap", w, 16'h0000);
        rd(STAT, b);        check("R6 flag on wrap", b, 8'h01);

        // R9 write-one-to-clear
        wr(STAT, 8'h00);
        rd(STAT, b);        check("R9 zero write keeps", b, 8'h01);
        // R10 interrupt gating
        wr(CTRL, 8'h00);
        idle(); #1 check("R10 irq masked", irq, 0);
        wr(CTRL, 8'h80);
        idle(); #1 check("R10 irq enabled", irq, 1);
        wr(STAT, 8'h01);
        rd(STAT, b);        check("R9 clear", b, 8'h00);
        check("R10 irq after clear", irq, 0);
        wr(CTRL, 8'h00);

        // R9 set wins over clear on the same edge
        load_word(CNT_LO, 16'hFFFF);
        wr(CTRL, 8'h01);
        wr(STAT, 8'h01);
        wr(CTRL, 8'h00);
        rd(STAT, b);        check("R9 set beats clear", b, 8'h01);
        rd_word(CNT_LO, w); check("R9 count after collision", w, 16'h0001);
        wr(STAT, 8'h01);

        // R7 / R8 / R6 step sweeps over small TOP values
        for (int md = 0; md < 3; md++) begin
            for (int tp = 0; tp < 6; tp++) begin
                logic [15:0] mc;
                logic        mdn, mh;
                logic [7:0]  base;
                base = {3'b000, 2'(md), 3'b000};
                wr(CTRL, 8'h00);
                load_word(TOP_LO, 16'(tp));
                mc = (md == 0) ? 16'hFFF8 : 16'h0000;
                mdn = 1'b0;
                load_word(CNT_LO, mc);
                wr(STAT, 8'h01);
                for (int s = 0; s < 14; s++) begin
                    model_step(md, 16'(tp), mc, mdn, mh);
                    run(1, base, 3'd1);
                    rd_word(CNT_LO, w);
                    rd(STAT, b);
                    if (md == 0) begin
                        check($sformatf("R6 step top=%0d s=%0d", tp, s), w, mc);
                        check("R6 flag step", b, mh);
                    end else if (md == 1) begin
                        check($sformatf("R7 step top=%0d s=%0d", tp, s), w, mc);
                        check("R7 flag step", b, mh);
                    end else begin
                        check($sformatf("R8 step top=%0d s=%0d", tp, s), w, mc);
                        check("R8 flag step", b, mh);
                    end
                    if (b[0]) wr(STAT, 8'h01);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule